// File: doc/BRIEF.md
# Sub-Vector Swizzle Register Index Unit

This block works out the physical register numbers for one group of sub-vector elements. It is given a base register, the element index `i` and the group size SUBVL (1 to LANES). For each sub-element slot `k` it returns the register `base + i*SUBVL + lane`. The value `lane` is normally `k`. When a swizzle is active it is instead taken from a packed field that holds one index per slot. The unit is purely combinational, so its outputs and its legality flag follow the inputs in the same cycle.

A swizzle takes effect only when it is enabled and SUBVL is at least 2. The block also judges whether the swizzle is legal:
- A swizzle on a source operand may read the same lane more than once.
- A swizzle on a destination operand must be a true permutation of the slots in use.
- In both roles, a slot in use may not name a lane at or beyond SUBVL.

Any violation raises an illegal-instruction flag.

Top module: `subvec_swizzle_idx`

## Requirements
- R1: When the swizzle is active, the lane for slot k is field bits [2k+1:2k] (slot 0 in [1:0], slot 1 in [3:2], slot 2 in [5:4], slot 3 in [7:6]), for every slot k below SUBVL.
- R2: With `swz_en` low, the lane for every slot k equals k, whatever the field holds.
- R3: With SUBVL = 1 (`subvl_m1` = 0), the lanes are the identity and the illegal flag stays low, even when `swz_en` is high.
- R4: The register for slot k equals (base_reg + elem_idx*SUBVL + lane_k) modulo 2^REG_W.
- R5: `lane_used[k]` is 1 exactly when k < SUBVL, where SUBVL = `subvl_m1` + 1.
- R6: For a source (`is_dest` = 0), an active swizzle whose used lanes repeat a value is legal.
- R7: For a destination (`is_dest` = 1), an active swizzle with two equal lanes among the used slots raises `swz_illegal`.
- R8: In either role, an active swizzle with a used lane index that is not below SUBVL raises `swz_illegal`.
- R9: Field bits belonging to slots at or above SUBVL do not change any lane, register or legality output. An unused slot reports lane k.
- R10: `swz_illegal` is low whenever the swizzle is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_reg | input | REG_W | Base register of the operand |
| elem_idx | input | IDX_W | Element index i of the current group |
| subvl_m1 | input | log2(LANES) | SUBVL minus one |
| swz_en | input | 1 | A swizzle entry is present for this operand |
| swz_field | input | LANES*log2(LANES) | Packed lane indices, slot 0 in the low bits |
| is_dest | input | 1 | 1 = destination operand, 0 = source operand |
| lane_sel | output | LANES*log2(LANES) | Lane chosen for each slot |
| lane_reg | output | LANES*REG_W | Physical register for each slot |
| lane_used | output | LANES | Slot lies inside the current group |
| swz_illegal | output | 1 | Illegal swizzle |

## Verification
Identity inputs are compared against fields that look like permutations, which shows that the swizzle takes effect only when it is enabled and SUBVL is 2 or more. An exhaustive sweep covers all 256 fields for SUBVL of 2, 3 and 4 in both roles. The sweep separates repeated lanes, which are legal for sources and illegal for destinations, from lanes that are out of range, which are illegal in both roles. Fields that differ only in unused slots must give identical outputs. Large bases and element indices check the modulo wrap of the register sum.

// File: rtl/swz_pkg.sv
package swz_pkg;
   typedef enum logic {
      SWZ_ROLE_SRC = 1'b0,
      SWZ_ROLE_DST = 1'b1
   } swz_role_e;

   // Largest group size the field layout is meant to describe
   localparam int unsigned SWZ_MAX_LANES = 16;
endpackage

// File: rtl/swz_lane_decode.sv
module swz_lane_decode #(
   parameter int LANES = 4,
   parameter int LW    = 2
) (
   input  logic [LANES*LW-1:0] field,
   input  logic [LW-1:0]       subvl_m1,
   input  logic                en,
   output logic [LANES*LW-1:0] sel,
   output logic [LANES-1:0]    used,
   output logic                active
);
   assign active = en && (subvl_m1 != '0);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign used[k] = (LW'(k) <= subvl_m1);
      assign sel[k*LW +: LW] = (active && used[k]) ? field[k*LW +: LW] : LW'(k);
   end
endmodule

// File: rtl/swz_perm_check.sv
module swz_perm_check
   import swz_pkg::*;
#(
   parameter int LANES = 4,
   parameter int LW    = 2
) (
   input  logic [LANES*LW-1:0] sel,
   input  logic [LANES-1:0]    used,
   input  logic [LW-1:0]       subvl_m1,
   input  logic                active,
   input  swz_role_e           role,
   output logic                illegal
);
   logic [LANES-1:0]       range_bad;
   logic [LANES*LANES-1:0] dup_m;

   for (genvar a = 0; a < LANES; a++) begin : g_row
      assign range_bad[a] = used[a] && (sel[a*LW +: LW] > subvl_m1);
      for (genvar b = 0; b < LANES; b++) begin : g_col
         if (b > a) begin : g_pair
            assign dup_m[a*LANES+b] = used[a] && used[b] &&
                                      (sel[a*LW +: LW] == sel[b*LW +: LW]);
         end else begin : g_none
            assign dup_m[a*LANES+b] = 1'b0;
         end
      end
   end

   assign illegal = active &&
                    ((|range_bad) || ((role == SWZ_ROLE_DST) && (|dup_m)));
endmodule

// File: rtl/swz_addr_gen.sv
module swz_addr_gen #(
   parameter int LANES = 4,
   parameter int LW    = 2,
   parameter int REG_W = 7,
   parameter int IDX_W = 6
) (
   input  logic [REG_W-1:0]       base_reg,
   input  logic [IDX_W-1:0]       elem_idx,
   input  logic [LW-1:0]          subvl_m1,
   input  logic [LANES*LW-1:0]    sel,
   output logic [LANES*REG_W-1:0] lane_reg
);
   localparam int PW = IDX_W + LW + 1;

   logic [PW-1:0]    grp_off;
   logic [REG_W-1:0] grp_base;

   // i*SUBVL written as i*(subvl_m1) + i
   assign grp_off  = PW'(elem_idx) * PW'(subvl_m1) + PW'(elem_idx);
   assign grp_base = base_reg + REG_W'(grp_off);

   for (genvar k = 0; k < LANES; k++) begin : g_reg
      assign lane_reg[k*REG_W +: REG_W] = grp_base + REG_W'(sel[k*LW +: LW]);
   end
endmodule

// File: rtl/subvec_swizzle_idx.sv
module subvec_swizzle_idx
   import swz_pkg::*;
#(
   parameter int  REG_W = 7,
   parameter int  IDX_W = 6,
   parameter int  LANES = 4,
   localparam int LW    = $clog2(LANES),
   localparam int FW    = LANES * LW
) (
   input  logic [REG_W-1:0]       base_reg,
   input  logic [IDX_W-1:0]       elem_idx,
   input  logic [LW-1:0]          subvl_m1,
   input  logic                   swz_en,
   input  logic [FW-1:0]          swz_field,
   input  logic                   is_dest,
   output logic [FW-1:0]          lane_sel,
   output logic [LANES*REG_W-1:0] lane_reg,
   output logic [LANES-1:0]       lane_used,
   output logic                   swz_illegal
);
   if (LANES < 2 || LANES > int'(SWZ_MAX_LANES) || (1 << LW) != LANES) begin : g_bad_lanes
      $error("LANES must be a power of two from 2 to %0d", SWZ_MAX_LANES);
   end
   if (REG_W <= LW) begin : g_bad_regw
      $error("REG_W must be wider than the lane index");
   end
   if (IDX_W < 1) begin : g_bad_idxw
      $error("IDX_W must be at least 1");
   end

   logic      active;
   swz_role_e role;

   assign role = is_dest ? SWZ_ROLE_DST : SWZ_ROLE_SRC;

   swz_lane_decode #(.LANES(LANES), .LW(LW)) u_decode (
      .field    (swz_field),
      .subvl_m1 (subvl_m1),
      .en       (swz_en),
      .sel      (lane_sel),
      .used     (lane_used),
      .active   (active)
   );

   swz_perm_check #(.LANES(LANES), .LW(LW)) u_check (
      .sel      (lane_sel),
      .used     (lane_used),
      .subvl_m1 (subvl_m1),
      .active   (active),
      .role     (role),
      .illegal  (swz_illegal)
   );

   swz_addr_gen #(.LANES(LANES), .LW(LW), .REG_W(REG_W), .IDX_W(IDX_W)) u_addr (
      .base_reg (base_reg),
      .elem_idx (elem_idx),
      .subvl_m1 (subvl_m1),
      .sel      (lane_sel),
      .lane_reg (lane_reg)
   );
endmodule

// File: rtl/subvec_swizzle_idx_chk.sv
module subvec_swizzle_idx_chk #(
   parameter int REG_W = 7,
   parameter int IDX_W = 6,
   parameter int LANES = 4,
   parameter int LW    = 2
) (
   input logic [REG_W-1:0]       base_reg,
   input logic [IDX_W-1:0]       elem_idx,
   input logic [LW-1:0]          subvl_m1,
   input logic                   swz_en,
   input logic                   is_dest,
   input logic [LANES*LW-1:0]    lane_sel,
   input logic [LANES*REG_W-1:0] lane_reg,
   input logic [LANES-1:0]       lane_used,
   input logic                   swz_illegal
);
   localparam int PW = IDX_W + LW + 1;

   logic [REG_W-1:0] grp_c;

   always_comb begin
      grp_c = base_reg + REG_W'(PW'(elem_idx) * (PW'(subvl_m1) + PW'(1)));
      for (int k = 0; k < LANES; k++) begin
         AST_USED_MASK: assert (lane_used[k] == (k <= int'(subvl_m1))) else $error("used mask"); // R5
         if (!swz_en)
            AST_IDENT_OFF: assert (lane_sel[k*LW +: LW] == LW'(k)) else $error("identity"); // R2
         AST_REG_SUM: assert (lane_reg[k*REG_W +: REG_W] - REG_W'(lane_sel[k*LW +: LW]) == grp_c)
            else $error("register sum"); // R4
      end
      if (!swz_en || subvl_m1 == '0)
         AST_NO_ILL_OFF: assert (!swz_illegal) else $error("illegal while off"); // R10
      if (swz_en && is_dest && subvl_m1 != '0 && lane_sel[0 +: LW] == lane_sel[LW +: LW])
         AST_DST_DUP: assert (swz_illegal) else $error("dest duplicate"); // R7
   end
endmodule

bind subvec_swizzle_idx subvec_swizzle_idx_chk #(
   .REG_W(REG_W), .IDX_W(IDX_W), .LANES(LANES), .LW(LW)
) u_chk (
   .base_reg    (base_reg),
   .elem_idx    (elem_idx),
   .subvl_m1    (subvl_m1),
   .swz_en      (swz_en),
   .is_dest     (is_dest),
   .lane_sel    (lane_sel),
   .lane_reg    (lane_reg),
   .lane_used   (lane_used),
   .swz_illegal (swz_illegal)
);

// File: tb/subvec_swizzle_idx_tb.sv
module subvec_swizzle_idx_tb;
   localparam int REG_W = 7;
   localparam int IDX_W = 6;
   localparam int LANES = 4;
   localparam int LW    = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [REG_W-1:0]       base_reg = '0;
   logic [IDX_W-1:0]       elem_idx = '0;
   logic [LW-1:0]          subvl_m1 = '0;
   logic                   swz_en = 1'b0;
   logic [7:0]             swz_field = '0;
   logic                   is_dest = 1'b0;
   logic [LANES*LW-1:0]    lane_sel;
   logic [LANES*REG_W-1:0] lane_reg;
   logic [LANES-1:0]       lane_used;
   logic                   swz_illegal;

   int checks = 0;
   int errors = 0;

   subvec_swizzle_idx #(.REG_W(REG_W), .IDX_W(IDX_W), .LANES(LANES)) u_dut (
      .base_reg(base_reg), .elem_idx(elem_idx), .subvl_m1(subvl_m1),
      .swz_en(swz_en), .swz_field(swz_field), .is_dest(is_dest),
      .lane_sel(lane_sel), .lane_reg(lane_reg), .lane_used(lane_used),
      .swz_illegal(swz_illegal)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic apply(int base, int elem, int sv, bit en, int fld, bit dst);
      @(negedge clk);
      base_reg  = REG_W'(base);
      elem_idx  = IDX_W'(elem);
      subvl_m1  = LW'(sv - 1);
      swz_en    = en;
      swz_field = 8'(fld);
      is_dest   = dst;
      #2;
   endtask

   // Expected values built from the requirement text
   task automatic expect_all(string tag);
      int  sv, lane[LANES];
      bit  act, ill;
      sv  = int'(subvl_m1) + 1;
      act = swz_en && sv >= 2;
      ill = 1'b0;
      for (int k = 0; k < LANES; k++) begin
         lane[k] = (act && k < sv) ? int'(swz_field[2*k +: 2]) : k;
         if (act && k < sv && lane[k] >= sv) ill = 1'b1;
      end
      for (int a = 0; a < sv; a++)
         for (int b = a + 1; b < sv; b++)
            if (act && is_dest && lane[a] == lane[b]) ill = 1'b1;
      for (int k = 0; k < LANES; k++) begin
         chk({tag, " lane"}, int'(lane_sel[k*LW +: LW]), lane[k]);
         chk({tag, " reg"}, int'(lane_reg[k*REG_W +: REG_W]),
             (int'(base_reg) + int'(elem_idx) * sv + lane[k]) % (1 << REG_W));
         chk({tag, " used"}, int'(lane_used[k]), int'(k < sv));
      end
      chk({tag, " illegal"}, int'(swz_illegal), int'(ill));
   endtask

   task automatic t_idle();
      apply(0, 0, 1, 0, 0, 0);
      expect_all("R2 idle");
      chk("R10 idle illegal", int'(swz_illegal), 0);
   endtask

   task automatic t_disabled();
      apply(10, 3, 4, 0, 8'h1B, 1);
      expect_all("R2 disabled");
      chk("R2 lane3", int'(lane_sel[6 +: 2]), 3);
   endtask

   task automatic t_subvl_one();
      apply(20, 5, 1, 1, 8'hFF, 1);
      expect_all("R3 subvl1");
      chk("R3 lane0", int'(lane_sel[1:0]), 0);
      chk("R3 reg0", int'(lane_reg[REG_W-1:0]), 25);
   endtask

   task automatic t_layout();
      apply(0, 2, 4, 1, 8'b00_01_10_11, 1);
      expect_all("R1 reverse");
      chk("R1 slot0", int'(lane_sel[1:0]), 3);
      chk("R4 slot0 reg", int'(lane_reg[REG_W-1:0]), 11);
      chk("R7 perm legal", int'(swz_illegal), 0);
   endtask

   task automatic t_src_dup();
      apply(8, 1, 4, 1, 8'h00, 0);
      expect_all("R6 src broadcast");
      chk("R6 no illegal", int'(swz_illegal), 0);
   endtask

   task automatic t_dst_dup();
      apply(8, 1, 4, 1, 8'b11_10_01_01, 1);
      expect_all("R7 dst dup");
      chk("R7 flag", int'(swz_illegal), 1);
   endtask

   task automatic t_range();
      apply(0, 0, 3, 1, 8'b00_11_01_00, 0);
      expect_all("R8 src range");
      chk("R8 src flag", int'(swz_illegal), 1);
      apply(0, 0, 2, 1, 8'b00_00_10_01, 1);
      chk("R8 dst flag", int'(swz_illegal), 1);
   endtask

   task automatic t_unused();
      apply(30, 4, 2, 1, 8'b00_00_00_01, 1);
      expect_all("R9 clean");
      apply(30, 4, 2, 1, 8'b11_11_00_01, 1);
      expect_all("R9 junk");
      chk("R9 illegal", int'(swz_illegal), 0);
      chk("R9 slot2 lane", int'(lane_sel[5:4]), 2);
      chk("R9 slot3 reg", int'(lane_reg[3*REG_W +: REG_W]), 41);
   endtask

   task automatic t_wrap();
      apply(120, 63, 4, 1, 8'b01_00_11_10, 1);
      expect_all("R4 wrap");
      chk("R4 wrap slot0", int'(lane_reg[REG_W-1:0]), (120 + 252 + 2) % 128);
   endtask

   task automatic t_sweep();
      for (int sv = 2; sv <= 4; sv++)
         for (int d = 0; d < 2; d++)
            for (int f = 0; f < 256; f++) begin
               apply(f % 97, f % 50, sv, 1, f, d[0]);
               expect_all(d != 0 ? "R7 R8 sweep dst" : "R6 R8 sweep src");
            end
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      t_idle();
      t_disabled();
      t_subvl_one();
      t_layout();
      t_src_dup();
      t_dst_dup();
      t_range();
      t_unused();
      t_wrap();
      t_sweep();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule